// File: doc/BRIEF.md
# Rounding Fixed-Point Complex Multiplier

This block multiplies two complex numbers. It is intended for the twiddle-factor rotation inside a pipelined FFT datapath. Each operand has a real part and an imaginary part. Both parts are signed two's complement fractions in the range [-1, 1) with W-1 fraction bits (W = 8 by default). The block forms the four cross products and cuts each one back to W bits. It then subtracts two of them to build the real result and adds the other two to build the imaginary result. Each result is W+1 bits wide.

A mode input, sampled together with each operand set, selects one of two ways to drop the low product bits:
- truncation, which rounds toward minus infinity;
- round-half-up.

With W+1 output bits, the final addition and subtraction are exact. The mode therefore acts only on the product reduction points.

Operands are qualified by `in_valid`. Each accepted set comes out three register stages later with `out_valid` raised. When no valid data passes, the data registers keep their contents.

Top module: `cmul_rnd`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid`, `out_re` and `out_im` to 0, whatever the other inputs do during reset.
- R2: An operand set presented with `in_valid`=1 on rising edge N appears on the outputs, with `out_valid`=1, just after rising edge N+2. `out_valid` reproduces the `in_valid` pattern with the same delay, including bubbles between samples.
- R3: `out_re` equals red(a_re·b_re) − red(a_im·b_im) as an exact signed W+1-bit value.
- R4: `out_im` equals red(a_re·b_im) + red(a_im·b_re) as an exact signed W+1-bit value.
- R5: With `rnd_mode`=0 (truncate), red(p) = floor(p / 2^(W-1)), where p is the integer product of the two W-bit operand codes.
- R6: With `rnd_mode`=1 (round), red(p) = floor((p + 2^(W-2)) / 2^(W-1)), which rounds half toward plus infinity.
- R7: A reduced product never wraps. Any value above 2^(W-1)−1 saturates to 2^(W-1)−1, so (−1)·(−1) gives 127 for W = 8.
- R8: `rnd_mode` is captured with its own operand set. Changing it on later cycles does not alter samples that are already in flight.
- R9: While `in_valid` is 0, `out_re` and `out_im` keep the values of the last valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set valid |
| rnd_mode | input | 1 | 0 = truncate, 1 = round half up |
| a_re | input | W | Real part of operand A |
| a_im | input | W | Imaginary part of operand A |
| b_re | input | W | Real part of operand B |
| b_im | input | W | Imaginary part of operand B |
| out_valid | output | 1 | Result valid |
| out_re | output | W+1 | Real part of the result |
| out_im | output | W+1 | Imaginary part of the result |

## Verification
Some internal faults are visible at the ports on the third edge after the affected sample. These include:
- a mode bit that is misaligned between pipeline stages;
- a rounding bias placed at the wrong bit;
- a missing saturation on the (−1)·(−1) product.

Each shows up as a result that is off by one LSB, or wrapped to a large negative value. Such a result differs from the bench's arithmetic model. Back-to-back samples with alternating modes expose stage misalignment within the same stream. A broken enable shows as output data that changes during a bubble, one cycle after the bubble enters the last stage.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    typedef enum logic {
        RM_TRUNC = 1'b0,
        RM_ROUND = 1'b1
    } rmode_e;

    typedef struct packed {
        logic   vld;
        rmode_e mode;
    } ctl_t;

    localparam int unsigned NLANE = 4;
    localparam int unsigned L_RR  = 0;   // a_re * b_re
    localparam int unsigned L_II  = 1;   // a_im * b_im
    localparam int unsigned L_RI  = 2;   // a_re * b_im
    localparam int unsigned L_IR  = 3;   // a_im * b_re

endpackage

// File: rtl/cmul_mul_stage.sv
module cmul_mul_stage
    import cmul_pkg::*;
#(
    parameter int unsigned W = 8,
    localparam int unsigned PW = 2 * W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [W-1:0]  a_re,
    input  logic signed [W-1:0]  a_im,
    input  logic signed [W-1:0]  b_re,
    input  logic signed [W-1:0]  b_im,
    input  ctl_t                 ctl_in,
    output logic signed [PW-1:0] prod_q [NLANE],
    output ctl_t                 ctl_q
);

    logic signed [W-1:0] opx [NLANE];
    logic signed [W-1:0] opy [NLANE];

    assign opx[L_RR] = a_re;  assign opy[L_RR] = b_re;
    assign opx[L_II] = a_im;  assign opy[L_II] = b_im;
    assign opx[L_RI] = a_re;  assign opy[L_RI] = b_im;
    assign opx[L_IR] = a_im;  assign opy[L_IR] = b_re;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic signed [PW-1:0] opx_w, opy_w;
        assign opx_w = PW'(opx[g]);
        assign opy_w = PW'(opy[g]);

        always_ff @(posedge clk) begin
            if (rst) begin
                prod_q[g] <= '0;
            end else if (ctl_in.vld) begin
                prod_q[g] <= opx_w * opy_w;
            end
        end

        // R9: no new sample, product register untouched
        p_prod_hold_r9: assert property (@(posedge clk) disable iff (rst)
            !ctl_in.vld |=> $stable(prod_q[g]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_in;
        end
    end

    p_vld_adv_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_in.vld |=> ctl_q.vld);
    p_bubble_adv_r2: assert property (@(posedge clk) disable iff (rst)
        !ctl_in.vld |=> !ctl_q.vld);
    p_mode_align_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_in.vld |=> ctl_q.mode == $past(ctl_in.mode));

endmodule

// File: rtl/cmul_round_stage.sv
module cmul_round_stage
    import cmul_pkg::*;
#(
    parameter int unsigned W = 8,
    localparam int unsigned PW = 2 * W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [PW-1:0] prod_in [NLANE],
    input  ctl_t                 ctl_in,
    output logic signed [W-1:0]  red_q [NLANE],
    output logic                 vld_q
);

    localparam logic signed [PW:0] HALF = (PW+1)'(1) << (W - 2);
    localparam logic signed [PW:0] MAXV = (PW+1)'((1 << (W - 1)) - 1);

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic signed [PW:0]  biased;
        logic signed [PW:0]  scaled;
        logic signed [W-1:0] red_d;

        always_comb begin
            biased = {prod_in[g][PW-1], prod_in[g]}
                   + ((ctl_in.mode == RM_ROUND) ? HALF : '0);
            scaled = biased >>> (W - 1);
            if (scaled > MAXV) begin
                red_d = MAXV[W-1:0];
            end else begin
                red_d = scaled[W-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                red_q[g] <= '0;
            end else if (ctl_in.vld) begin
                red_q[g] <= red_d;
            end
        end

        // R7: non-negative product never turns into a negative code
        p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
            (ctl_in.vld && !prod_in[g][PW-1]) |=> !red_q[g][W-1]);
        // R5: flooring keeps negative products negative
        p_floor_sign_r5: assert property (@(posedge clk) disable iff (rst)
            (ctl_in.vld && ctl_in.mode == RM_TRUNC && prod_in[g][PW-1])
            |=> red_q[g][W-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= ctl_in.vld;
        end
    end

endmodule

// File: rtl/cmul_combine_stage.sv
module cmul_combine_stage
    import cmul_pkg::*;
#(
    parameter int unsigned W = 8,
    localparam int unsigned OW = W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] red_in [NLANE],
    input  logic                vld_in,
    output logic signed [OW-1:0] out_re,
    output logic signed [OW-1:0] out_im,
    output logic                 out_valid
);

    logic signed [OW-1:0] ext [NLANE];
    logic signed [OW-1:0] re_d, im_d;

    for (genvar g = 0; g < NLANE; g++) begin : g_ext
        assign ext[g] = {red_in[g][W-1], red_in[g]};
    end

    assign re_d = ext[L_RR] - ext[L_II];
    assign im_d = ext[L_RI] + ext[L_IR];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_re    <= '0;
            out_im    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= vld_in;
            if (vld_in) begin
                out_re <= re_d;
                out_im <= im_d;
            end
        end
    end

    p_re_positive_r3: assert property (@(posedge clk) disable iff (rst)
        (vld_in && !red_in[L_RR][W-1] && red_in[L_II][W-1])
        |=> (!out_re[OW-1] && out_re != '0));
    p_im_nonneg_r4: assert property (@(posedge clk) disable iff (rst)
        (vld_in && !red_in[L_RI][W-1] && !red_in[L_IR][W-1])
        |=> !out_im[OW-1]);
    p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !vld_in |=> ($stable(out_re) && $stable(out_im)));

endmodule

// File: rtl/cmul_rnd.sv
module cmul_rnd
    import cmul_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                rnd_mode,
    input  logic signed [W-1:0] a_re,
    input  logic signed [W-1:0] a_im,
    input  logic signed [W-1:0] b_re,
    input  logic signed [W-1:0] b_im,
    output logic                out_valid,
    output logic signed [W:0]   out_re,
    output logic signed [W:0]   out_im
);

    localparam int unsigned PW = 2 * W;

    ctl_t                 ctl_in, ctl_s1;
    logic signed [PW-1:0] prod_s1 [NLANE];
    logic signed [W-1:0]  red_s2  [NLANE];
    logic                 vld_s2;

    assign ctl_in.vld  = in_valid;
    assign ctl_in.mode = rmode_e'(rnd_mode);

    cmul_mul_stage #(.W(W)) u_mul (
        .clk    (clk),
        .rst    (rst),
        .a_re   (a_re),
        .a_im   (a_im),
        .b_re   (b_re),
        .b_im   (b_im),
        .ctl_in (ctl_in),
        .prod_q (prod_s1),
        .ctl_q  (ctl_s1)
    );

    cmul_round_stage #(.W(W)) u_red (
        .clk     (clk),
        .rst     (rst),
        .prod_in (prod_s1),
        .ctl_in  (ctl_s1),
        .red_q   (red_s2),
        .vld_q   (vld_s2)
    );

    cmul_combine_stage #(.W(W)) u_comb (
        .clk       (clk),
        .rst       (rst),
        .red_in    (red_s2),
        .vld_in    (vld_s2),
        .out_re    (out_re),
        .out_im    (out_im),
        .out_valid (out_valid)
    );

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_re == '0 && out_im == '0));

endmodule

// File: tb/cmul_rnd_test.sv
module cmul_rnd_test;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, rnd_mode;
    logic signed [7:0] a_re, a_im, b_re, b_im;
    logic out_valid;
    logic signed [8:0] out_re, out_im;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    cmul_rnd #(.W(8)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .rnd_mode(rnd_mode),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    function automatic int red(int a, int b, bit m);
        int p, r;
        p = a * b;
        r = m ? ((p + 64) >>> 7) : (p >>> 7);
        if (r > 127) r = 127;
        return r;
    endfunction

    function automatic int exp_re(int ar, int ai, int br, int bi, bit m);
        return red(ar, br, m) - red(ai, bi, m);
    endfunction

    function automatic int exp_im(int ar, int ai, int br, int bi, bit m);
        return red(ar, bi, m) + red(ai, br, m);
    endfunction

    task automatic chk(string req, int act, int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic drive(int ar, int ai, int br, int bi, bit m, bit v);
        a_re = 8'(ar); a_im = 8'(ai); b_re = 8'(br); b_im = 8'(bi);
        rnd_mode = m; in_valid = v;
    endtask

    // R1: reset clears outputs even with valid traffic present
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        drive(100, -50, 77, 33, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 out_re", int'(out_re), 0);
        chk("R1 out_im", int'(out_im), 0);
        drive(0, 0, 0, 0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid after release", int'(out_valid), 0);
    endtask

    // one sample, checked after the third negedge (edges N, N+1, N+2)
    task automatic t_single(string req, int ar, int ai, int br, int bi, bit m);
        @(negedge clk);
        drive(ar, ai, br, bi, m, 1'b1);
        @(negedge clk);
        drive(-1, 5, 9, -7, ~m, 1'b0);
        @(negedge clk);
        chk({req, " R2 not early"}, int'(out_valid), 0);
        @(negedge clk);
        chk({req, " R2 valid"}, int'(out_valid), 1);
        chk({req, " R3 re"}, int'(out_re), exp_re(ar, ai, br, bi, m));
        chk({req, " R4 im"}, int'(out_im), exp_im(ar, ai, br, bi, m));
        @(negedge clk);
        chk({req, " R2 single pulse"}, int'(out_valid), 0);
    endtask

    // R2, R8, R9: streamed samples with bubbles and alternating mode
    task automatic t_stream();
        int ar [8] = '{ 64, -64, 127, -128, 100,  3, -77,  50};
        int ai [8] = '{  3,  -3, -128,  127, -90, 64,  45, -50};
        int br [8] = '{  3,   3, 127, -128,  33, -3, 101,  51};
        int bi [8] = '{-64,  64,  -1,   -1, -99, 64, -13,  -9};
        bit md [8] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
        bit vv [8] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
        int last_re = 0, last_im = 0;
        for (int t = 0; t < 11; t++) begin
            @(negedge clk);
            if (t >= 3) begin
                int k = t - 3;
                chk("R2 stream valid", int'(out_valid), int'(vv[k]));
                if (vv[k]) begin
                    last_re = exp_re(ar[k], ai[k], br[k], bi[k], md[k]);
                    last_im = exp_im(ar[k], ai[k], br[k], bi[k], md[k]);
                    chk("R8 stream re", int'(out_re), last_re);
                    chk("R8 stream im", int'(out_im), last_im);
                end else begin
                    chk("R9 hold re", int'(out_re), last_re);
                    chk("R9 hold im", int'(out_im), last_im);
                end
            end
            if (t < 8) drive(ar[t], ai[t], br[t], bi[t], md[t], vv[t]);
            else       drive(11, -22, 33, -44, 1'b1, 1'b0);
        end
    endtask

    initial begin
        rst = 1'b0;
        drive(0, 0, 0, 0, 1'b0, 1'b0);
        t_reset();
        // R5: 64*3=192 -> floor 1; -64*3 -> floor -2
        t_single("R5 trunc", 64, -64, 3, 3, 1'b0);
        // R6: same operands rounded -> 2 and -1
        t_single("R6 round", 64, -64, 3, 3, 1'b1);
        // R7: (-1)*(-1) saturates to 127 in both modes
        t_single("R7 sat trunc", -128, -128, -128, -128, 1'b0);
        t_single("R7 sat round", -128, 127, -128, 127, 1'b1);
        t_single("R3 extreme re", 127, -128, 127, 127, 1'b0);
        t_single("R4 extreme im", -128, -128, 127, 127, 1'b1);
        t_single("R3 mixed", -77, 45, 101, -13, 1'b0);
        t_stream();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule